// File: doc/BRIEF.md
# Link Activity Statistics Bank

This block watches the traffic of a serial link's user side and keeps a bank of counters that software or a debug probe can read one at a time. It samples two inbound and two outbound streaming ports, a strobe that marks the start of each packet, and eight single-cycle event strobes. These strobes cover negative acknowledgements, requests, retries (each sent and received), disparity errors and routing-table misses.

Two kinds of counter are kept. Rate counters accumulate over fixed windows of cycles that a free-running cycle counter marks out. At the end of each window the running total moves into a readable register and the accumulator restarts, so a read always shows the most recent completed window. The short window covers packets and the four ports' transfer beats, and a long window covers packets only. Event totals run from reset and stop at their maximum value instead of wrapping. A 4-bit read address picks one value, and the chosen value appears on the registered read data output one clock later.

Top module: `link_stats_bank`

## Requirements
- R1: Address 0x0 returns the number of cycles with `pkt_start` high in the last completed short window of 2^SHORT_LOG cycles (default 2^10).
- R2: Address 0x1 returns the number of cycles with `pkt_start` high in the last completed long window of 2^LONG_LOG cycles (default 2^20). A long window boundary is also a short window boundary.
- R3: Addresses 0x2 and 0x3 return, for inbound ports 1 and 2, the number of cycles in the last completed short window in which that port's valid and ready were both high. A cycle with only one of the two high is not counted.
- R4: Addresses 0x4 and 0x5 return the same beat count for outbound ports 1 and 2.
- R5: Windows are consecutive and start at the first clock after reset is released. A windowed value stays constant for the whole window that follows the one it describes, and a window with no activity reads 0 once it completes.
- R6: Event totals since reset are read at 0x6 `nack_tx`, 0x7 `nack_rx`, 0x8 `req_tx`, 0x9 `req_rx`, 0xa `disp_err`, 0xb `tbl_miss`, 0xc `retry_tx` and 0xd `retry_rx`. Each cycle with the strobe high adds one.
- R7: An event total of TOT_W bits (default 32) stops at all ones and never wraps.
- R8: Addresses 0xe and 0xf read as zero.
- R9: `rd_data` is registered. It shows the value selected by `rd_addr` at the previous rising clock edge and does not change between edges.
- R10: While `rst_n` is low, `rd_data` and every counter are zero. After a reset in mid-run, every address reads zero until new activity arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in1_valid | input | 1 | Inbound port 1 valid |
| in1_ready | input | 1 | Inbound port 1 ready |
| in2_valid | input | 1 | Inbound port 2 valid |
| in2_ready | input | 1 | Inbound port 2 ready |
| out1_valid | input | 1 | Outbound port 1 valid |
| out1_ready | input | 1 | Outbound port 1 ready |
| out2_valid | input | 1 | Outbound port 2 valid |
| out2_ready | input | 1 | Outbound port 2 ready |
| pkt_start | input | 1 | One cycle per observed packet |
| nack_tx | input | 1 | Packet-not-accepted sent strobe |
| nack_rx | input | 1 | Packet-not-accepted received strobe |
| req_tx | input | 1 | Request sent strobe |
| req_rx | input | 1 | Request received strobe |
| disp_err | input | 1 | Disparity error strobe |
| tbl_miss | input | 1 | Routing-table miss error strobe |
| retry_tx | input | 1 | Retry sent strobe |
| retry_rx | input | 1 | Retry received strobe |
| rd_addr | input | 4 | Counter select |
| rd_data | output | DATA_W | Selected counter, registered |

## Verification
The rate counters are driven with stimulus vectors that each fill one short window. Each vector feeds bit masks to the four ports so that valid-only, ready-only and valid-with-ready cycles all occur. A valid-only or ready-only cycle that is wrongly counted, or a port that is wrongly swapped, therefore shows up as a different count. The vectors include full windows with every cycle active and completely idle windows, so the boundary value of exactly 2^SHORT_LOG and the latch-and-clear step are both exercised. A long run with packets on every third cycle separates the long window from the short one. Each event strobe is pulsed a different number of times, which exposes crossed addresses, and one strobe is pulsed past the maximum to show that the total stops instead of wrapping.

// File: rtl/link_stats_pkg.sv
package link_stats_pkg;

  typedef enum logic [3:0] {
    SEL_PKT_SHORT = 4'h0,
    SEL_PKT_LONG  = 4'h1,
    SEL_IN1_BEATS = 4'h2,
    SEL_IN2_BEATS = 4'h3,
    SEL_OUT1_BEATS = 4'h4,
    SEL_OUT2_BEATS = 4'h5,
    SEL_NACK_TX   = 4'h6,
    SEL_NACK_RX   = 4'h7,
    SEL_REQ_TX    = 4'h8,
    SEL_REQ_RX    = 4'h9,
    SEL_DISP_ERR  = 4'ha,
    SEL_TBL_MISS  = 4'hb,
    SEL_RETRY_TX  = 4'hc,
    SEL_RETRY_RX  = 4'hd
  } stat_sel_e;

  localparam int unsigned NUM_SHORT = 5;  // pkt, in1, in2, out1, out2
  localparam int unsigned NUM_EVENT = 8;  // 0x6 .. 0xd in order

endpackage

// File: rtl/stat_window_ctr.sv
module stat_window_ctr #(
  parameter int unsigned WIN_LOG = 10,
  parameter int unsigned CNT_W   = WIN_LOG + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_end,
  input  logic             inc,
  output logic [CNT_W-1:0] last_win
);

  localparam logic [CNT_W-1:0] WIN_LEN = CNT_W'(1) << WIN_LOG;

  logic [CNT_W-1:0] acc_q, acc_d, acc_sum;
  logic [CNT_W-1:0] last_q, last_d;

  always_comb begin
    acc_sum = acc_q + CNT_W'(inc);
    if (win_end) begin
      acc_d  = '0;
      last_d = acc_sum;
    end else begin
      acc_d  = acc_sum;
      last_d = last_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      last_q <= '0;
    end else begin
      acc_q  <= acc_d;
      last_q <= last_d;
    end
  end

  assign last_win = last_q;

  // R5: published value only moves at a window end
  a_r5_hold_between_ends: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> $stable(last_q));

  // R5: a window can never hold more beats than it has cycles
  a_r5_window_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q <= WIN_LEN) && (last_q <= WIN_LEN));

endmodule

// File: rtl/stat_total_ctr.sv
module stat_total_ctr #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] total
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_max;

  always_comb begin
    at_max = &cnt_q;
    cnt_d  = cnt_q;
    if (inc && !at_max) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign total = cnt_q;

  // R7: once full, the total stays full
  a_r7_sat_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (&total) |=> (&total));

  // R6: totals never decrease between resets
  a_r6_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (total >= $past(total)));

endmodule

// File: rtl/link_stats_bank.sv
module link_stats_bank
  import link_stats_pkg::*;
#(
  parameter int unsigned SHORT_LOG = 10,
  parameter int unsigned LONG_LOG  = 20,
  parameter int unsigned TOT_W     = 32,
  parameter int unsigned DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in1_valid,
  input  logic              in1_ready,
  input  logic              in2_valid,
  input  logic              in2_ready,
  input  logic              out1_valid,
  input  logic              out1_ready,
  input  logic              out2_valid,
  input  logic              out2_ready,
  input  logic              pkt_start,
  input  logic              nack_tx,
  input  logic              nack_rx,
  input  logic              req_tx,
  input  logic              req_rx,
  input  logic              disp_err,
  input  logic              tbl_miss,
  input  logic              retry_tx,
  input  logic              retry_rx,
  input  logic [3:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  localparam int unsigned SHORT_W = SHORT_LOG + 1;
  localparam int unsigned LONG_W  = LONG_LOG + 1;

  // ---- reset release synchronizer ----
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // ---- free-running cycle counter marking window ends ----
  logic [LONG_LOG-1:0] cyc_q, cyc_d;
  logic                short_end, long_end;

  always_comb begin
    cyc_d     = cyc_q + LONG_LOG'(1);
    short_end = &cyc_q[SHORT_LOG-1:0];
    long_end  = &cyc_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) cyc_q <= '0;
    else            cyc_q <= cyc_d;
  end

  // ---- short-window counters ----
  logic [NUM_SHORT-1:0] short_inc;
  logic [SHORT_W-1:0]   short_val [NUM_SHORT];

  assign short_inc = {out2_valid & out2_ready,
                      out1_valid & out1_ready,
                      in2_valid  & in2_ready,
                      in1_valid  & in1_ready,
                      pkt_start};

  for (genvar g = 0; g < NUM_SHORT; g++) begin : g_short
    stat_window_ctr #(
      .WIN_LOG (SHORT_LOG),
      .CNT_W   (SHORT_W)
    ) u_win (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .win_end  (short_end),
      .inc      (short_inc[g]),
      .last_win (short_val[g])
    );
  end

  // ---- long-window packet counter ----
  logic [LONG_W-1:0] long_val;

  stat_window_ctr #(
    .WIN_LOG (LONG_LOG),
    .CNT_W   (LONG_W)
  ) u_long_win (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .win_end  (long_end),
    .inc      (pkt_start),
    .last_win (long_val)
  );

  // ---- saturating event totals ----
  logic [NUM_EVENT-1:0] ev_inc;
  logic [TOT_W-1:0]     ev_val [NUM_EVENT];

  assign ev_inc = {retry_rx, retry_tx, tbl_miss, disp_err,
                   req_rx, req_tx, nack_rx, nack_tx};

  for (genvar e = 0; e < NUM_EVENT; e++) begin : g_event
    stat_total_ctr #(
      .CNT_W (TOT_W)
    ) u_tot (
      .clk   (clk),
      .rst_n (rst_int_n),
      .inc   (ev_inc[e]),
      .total (ev_val[e])
    );
  end

  // ---- read select and output register ----
  logic [DATA_W-1:0] sel_d;

  always_comb begin
    sel_d = '0;
    case (rd_addr)
      SEL_PKT_SHORT:  sel_d = DATA_W'(short_val[0]);
      SEL_PKT_LONG:   sel_d = DATA_W'(long_val);
      SEL_IN1_BEATS:  sel_d = DATA_W'(short_val[1]);
      SEL_IN2_BEATS:  sel_d = DATA_W'(short_val[2]);
      SEL_OUT1_BEATS: sel_d = DATA_W'(short_val[3]);
      SEL_OUT2_BEATS: sel_d = DATA_W'(short_val[4]);
      SEL_NACK_TX:    sel_d = DATA_W'(ev_val[0]);
      SEL_NACK_RX:    sel_d = DATA_W'(ev_val[1]);
      SEL_REQ_TX:     sel_d = DATA_W'(ev_val[2]);
      SEL_REQ_RX:     sel_d = DATA_W'(ev_val[3]);
      SEL_DISP_ERR:   sel_d = DATA_W'(ev_val[4]);
      SEL_TBL_MISS:   sel_d = DATA_W'(ev_val[5]);
      SEL_RETRY_TX:   sel_d = DATA_W'(ev_val[6]);
      SEL_RETRY_RX:   sel_d = DATA_W'(ev_val[7]);
      default:        sel_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) rd_data <= '0;
    else            rd_data <= sel_d;
  end

  // R8: spare addresses read zero one cycle later
  a_r8_spare_zero: assert property (@(posedge clk) disable iff (!rst_int_n)
    (rd_addr >= 4'he) |=> (rd_data == '0));

  // R2: the long window end always coincides with a short window end
  a_r2_nested_ends: assert property (@(posedge clk) disable iff (!rst_int_n)
    long_end |-> short_end);

endmodule

// File: tb/link_stats_bank_test.sv
`timescale 1ns/1ps
module link_stats_bank_test;

  localparam int unsigned S_LOG = 4;
  localparam int unsigned L_LOG = 6;
  localparam int unsigned T_W   = 6;
  localparam int unsigned D_W   = 32;
  localparam int unsigned WIN   = 1 << S_LOG;
  localparam int unsigned NVEC  = 4;

  // each vector: {valid_mask, ready_mask, pkt_mask}, bit t drives window cycle t
  localparam logic [47:0] VEC [NVEC] = '{
    {16'hFFFF, 16'hFFFF, 16'h0000},
    {16'h0000, 16'h0000, 16'hFFFF},
    {16'hAAAA, 16'hCCCC, 16'hF0F0},
    {16'h0F0F, 16'h3333, 16'h8001}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic in1_valid, in1_ready, in2_valid, in2_ready;
  logic out1_valid, out1_ready, out2_valid, out2_ready;
  logic pkt_start;
  logic [7:0] ev;
  logic [3:0] rd_addr;
  logic [D_W-1:0] rd_data;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  link_stats_bank #(
    .SHORT_LOG (S_LOG),
    .LONG_LOG  (L_LOG),
    .TOT_W     (T_W),
    .DATA_W    (D_W)
  ) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .in1_valid  (in1_valid),
    .in1_ready  (in1_ready),
    .in2_valid  (in2_valid),
    .in2_ready  (in2_ready),
    .out1_valid (out1_valid),
    .out1_ready (out1_ready),
    .out2_valid (out2_valid),
    .out2_ready (out2_ready),
    .pkt_start  (pkt_start),
    .nack_tx    (ev[0]),
    .nack_rx    (ev[1]),
    .req_tx     (ev[2]),
    .req_rx     (ev[3]),
    .disp_err   (ev[4]),
    .tbl_miss   (ev[5]),
    .retry_tx   (ev[6]),
    .retry_rx   (ev[7]),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data)
  );

  task automatic check(input string req, input logic [D_W-1:0] act, input logic [D_W-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle_inputs();
    {in1_valid, in1_ready, in2_valid, in2_ready} = '0;
    {out1_valid, out1_ready, out2_valid, out2_ready} = '0;
    pkt_start = 1'b0;
    ev = '0;
  endtask

  task automatic read_chk(input string req, input logic [3:0] a, input logic [D_W-1:0] exp);
    rd_addr = a;
    tick();
    check(req, rd_data, exp);
  endtask

  task automatic release_reset();
    rst_n = 1'b1;
    tick();
    tick();
  endtask

  initial begin
    logic [15:0] v, r, p;
    logic [D_W-1:0] hold;
    rst_n = 1'b0;
    rd_addr = 4'h0;
    idle_inputs();
    repeat (3) tick();
    // R10: output held at zero in reset
    check("R10 reset rd_data", rd_data, '0);
    release_reset();

    // ---- table walk: one stimulus window, then one read window ----
    for (int i = 0; i < NVEC; i++) begin
      {v, r, p} = VEC[i];
      for (int t = 0; t < WIN; t++) begin
        in1_valid  = v[t];  in1_ready  = r[t];
        in2_valid  = v[t];  in2_ready  = ~r[t];
        out1_valid = r[t];  out1_ready = p[t];
        out2_valid = ~v[t]; out2_ready = ~p[t];
        pkt_start  = p[t];
        tick();
      end
      idle_inputs();
      read_chk("R1 short pkt",   4'h0, D_W'($countones(p)));
      read_chk("R3 in1 beats",   4'h2, D_W'($countones(v & r)));
      read_chk("R3 in2 beats",   4'h3, D_W'($countones(v & ~r)));
      read_chk("R4 out1 beats",  4'h4, D_W'($countones(r & p)));
      read_chk("R4 out2 beats",  4'h5, D_W'($countones(~v & ~p)));
      // R5: value still held late in the following window
      repeat (WIN - 6) tick();
      read_chk("R5 hold in1",    4'h2, D_W'($countones(v & r)));
    end

    // ---- long window: packets every third cycle over one long window ----
    for (int t = 0; t < (1 << L_LOG); t++) begin
      pkt_start = (t % 3 == 0);
      tick();
    end
    pkt_start = 1'b0;
    read_chk("R2 long pkt", 4'h1, 32'd22);
    read_chk("R1 short pkt last window", 4'h0, 32'd6);

    // ---- event totals: strobe k pulsed k+1 times ----
    for (int k = 0; k < 8; k++) begin
      for (int n = 0; n <= k; n++) begin
        ev = 8'(1 << k);
        tick();
      end
      ev = '0;
    end
    tick();
    for (int k = 0; k < 8; k++)
      read_chk("R6 event total", 4'(6 + k), D_W'(k + 1));

    // R8: spare addresses
    read_chk("R8 addr e", 4'he, '0);
    read_chk("R8 addr f", 4'hf, '0);

    // R9: rd_data steady between edges, follows address after one edge
    hold = rd_data;
    rd_addr = 4'h8;
    #1;
    check("R9 no change before edge", rd_data, hold);
    tick();
    check("R9 after edge", rd_data, 32'd3);

    // R7: push retry_rx past the maximum
    ev[7] = 1'b1;
    repeat (70) tick();
    ev = '0;
    read_chk("R7 saturated", 4'hd, D_W'((1 << T_W) - 1));
    repeat (3) tick();
    read_chk("R7 stays saturated", 4'hd, D_W'((1 << T_W) - 1));

    // R5: after idle windows the windowed values read zero
    repeat (2 * WIN) tick();
    read_chk("R5 idle window zero", 4'h3, '0);

    // R10: mid-run reset clears totals and windows
    rst_n = 1'b0;
    tick();
    check("R10 rd_data in reset", rd_data, '0);
    release_reset();
    read_chk("R10 total cleared", 4'hd, '0);
    read_chk("R10 nack cleared", 4'h6, '0);
    read_chk("R10 long cleared", 4'h1, '0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule